// File: doc/BRIEF.md
# Escalating Watchdog Timer with Programmable Prescaler

This block watches over running software. A free-running prescale counter divides the block clock by a programmable amount. Each time the prescaler completes a period, a timer counter steps up by one. Two compare values are checked against the timer counter. The first one sets a latched interrupt request, to warn that software is late. The second one, when armed, emits a one-cycle request that asks the chip-level reset generator to restart the device. Software keeps the device alive by writing the reload register often enough. That write zeroes both counters before either compare value is reached.

Clearing the reset-arm bit leaves the block as a general-purpose interval timer. In that mode the first compare value still raises the interrupt flag. A sticky cause flag records that a watchdog reset request was issued. It lives through the system reset that follows, so that boot code can tell why the chip restarted. Only a power-on reset or a software clear removes it. Registers are reached over a simple APB-style bus, with setup and access phases and no wait states.

Top module: `escal_watchdog`

## Requirements
- R1: After power-on reset every register reads zero, and both `irq_o` and `rst_req_o` are low.
- R2: While running, the prescale counter increments on each clock. On the edge where it equals the prescale value (offset 0x08), it returns to zero and the timer counter steps by one. A compare value K is therefore reached K*(P+1) clocks after the counters start from zero, where P is the prescale value.
- R3: On the edge where the timer counter steps onto compare value 0 (offset 0x10), status bit 0 (offset 0x18) sets. `irq_o` equals that bit ANDed with control bit 2. The bit stays set until software writes 1 to status bit 0.
- R4: On the edge where the timer counter steps onto compare value 1 (offset 0x14) with control bit 3 set, `rst_req_o` is high for exactly one cycle.
- R5: Status bit 1 sets together with each reset request. It keeps its value through `rst_n`. It clears only on a write of 1 to status bit 1, or on `por_n`.
- R6: Any write to the reload register (offset 0x1C) clears both counters, and so does a control write with bit 1 set. Either clear takes priority over counting on the same edge.
- R7: While control bit 0 (run) is clear, both counters hold their values and no compare event occurs.
- R8: A compare event fires only on the edge where the timer counter steps onto the compare value. It does not fire while the two values merely stay equal. Stepping past the all-ones value wraps to zero and can match a compare value of zero.
- R9: Writes to unassigned or unaligned offsets change nothing, and reads from them return zero.
- R10: Register map: control 0x00 (bit0 run, bit1 clear, bit2 interrupt enable, bit3 reset arm; the clear bit reads 0), timer counter 0x04 (read-only), prescale 0x08, prescale counter 0x0C (read-only), compare 0 at 0x10, compare 1 at 0x14, status 0x18 (write-1-to-clear), reload 0x1C (reads 0).
- R11: With control bit 3 clear, reaching compare value 1 produces no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, spares the cause flag |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, zero outside the access phase |
| irq_o | output | 1 | Latched early-warning interrupt request |
| rst_req_o | output | 1 | One-cycle chip reset request |

## Verification
The main function is swept over every prescale value of a narrowed configuration, combined with several compare values. Measuring the clocks to the interrupt separates an off-by-one in the prescaler from one in the compare. A compare value of zero with a divide-by-one prescaler can only be met after a full wrap of the timer counter. This tells edge-triggered matching apart from level matching. A large prescale value with a compare of one keeps the counter parked on the match value after the flag is cleared, which exposes re-triggering. Further sequences set the reset request against the earlier interrupt, and check the cause flag across each of the two resets.

// File: rtl/ewd_pkg.sv
`timescale 1ns/1ps
package ewd_pkg;

   localparam int NMATCH = 2;

   localparam int OFS_CTRL = 'h00;
   localparam int OFS_TCNT = 'h04;
   localparam int OFS_PSCL = 'h08;
   localparam int OFS_PCNT = 'h0C;
   localparam int OFS_MAT0 = 'h10;
   localparam int OFS_MAT1 = 'h14;
   localparam int OFS_STAT = 'h18;
   localparam int OFS_FEED = 'h1C;

   localparam int WIN_BITS = 5;

   typedef enum logic [2:0] {
      IDX_CTRL = 3'd0,
      IDX_TCNT = 3'd1,
      IDX_PSCL = 3'd2,
      IDX_PCNT = 3'd3,
      IDX_MAT0 = 3'd4,
      IDX_MAT1 = 3'd5,
      IDX_STAT = 3'd6,
      IDX_FEED = 3'd7
   } reg_idx_e;

   localparam int CB_RUN   = 0;
   localparam int CB_CLR   = 1;
   localparam int CB_IRQEN = 2;
   localparam int CB_RSTEN = 3;

   localparam int SB_M0    = 0;
   localparam int SB_CAUSE = 1;

   typedef struct packed {
      logic rst_en;
      logic irq_en;
      logic run;
   } ctrl_t;

endpackage

// File: rtl/ewd_counters.sv
`timescale 1ns/1ps
module ewd_counters #(
   parameter int CNT_W = 32,
   parameter int PRE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [PRE_W-1:0] pscl_i,
   output logic [PRE_W-1:0] pcnt_o,
   output logic [CNT_W-1:0] tcnt_o,
   output logic             step_o,
   output logic [CNT_W-1:0] tnext_o
);

   logic pdone;

   assign pdone   = (pcnt_o == pscl_i);
   assign step_o  = run_i & ~clr_i & pdone;
   assign tnext_o = tcnt_o + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_o <= '0;
         tcnt_o <= '0;
      end else if (clr_i) begin
         pcnt_o <= '0;
         tcnt_o <= '0;
      end else if (run_i) begin
         if (pdone) begin
            pcnt_o <= '0;
            tcnt_o <= tnext_o;
         end else begin
            pcnt_o <= pcnt_o + PRE_W'(1);
         end
      end
   end

endmodule

// File: rtl/ewd_match.sv
`timescale 1ns/1ps
module ewd_match #(
   parameter int CNT_W = 32
) (
   input  logic             step_i,
   input  logic [CNT_W-1:0] tnext_i,
   input  logic [CNT_W-1:0] mval_i,
   output logic             hit_o
);

   // Fires only when the counter is about to land on the value.
   assign hit_o = step_i & (tnext_i == mval_i);

endmodule

// File: rtl/ewd_regs.sv
`timescale 1ns/1ps
module ewd_regs
   import ewd_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         por_n,
   input  logic                         psel_i,
   input  logic                         penable_i,
   input  logic                         pwrite_i,
   input  logic [ADDR_W-1:0]            paddr_i,
   input  logic [DATA_W-1:0]            pwdata_i,
   output logic [DATA_W-1:0]            prdata_o,
   input  logic [CNT_W-1:0]             tcnt_i,
   input  logic [PRE_W-1:0]             pcnt_i,
   input  logic [NMATCH-1:0]            hit_i,
   output ctrl_t                        ctrl_o,
   output logic                         clr_o,
   output logic [PRE_W-1:0]             pscl_o,
   output logic [NMATCH-1:0][CNT_W-1:0] mval_o,
   output logic                         m0_flag_o,
   output logic                         cause_o,
   output logic                         rst_req_o
);

   logic     in_win;
   logic     wr;
   reg_idx_e idx;
   logic     wr_ctrl, wr_pscl, wr_stat, wr_feed;
   logic     fire_rst;

   generate
      if (ADDR_W > WIN_BITS) begin : g_wide
         assign in_win = (paddr_i[ADDR_W-1:WIN_BITS] == '0) && (paddr_i[1:0] == 2'b00);
      end else begin : g_exact
         assign in_win = (paddr_i[1:0] == 2'b00);
      end
   endgenerate

   assign idx     = reg_idx_e'(paddr_i[WIN_BITS-1:2]);
   assign wr      = psel_i & penable_i & pwrite_i & in_win;
   assign wr_ctrl = wr && (idx == IDX_CTRL);
   assign wr_pscl = wr && (idx == IDX_PSCL);
   assign wr_stat = wr && (idx == IDX_STAT);
   assign wr_feed = wr && (idx == IDX_FEED);

   assign clr_o    = wr_feed | (wr_ctrl & pwdata_i[CB_CLR]);
   assign fire_rst = hit_i[1] & ctrl_o.rst_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '0;
         pscl_o <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_o.run    <= pwdata_i[CB_RUN];
            ctrl_o.irq_en <= pwdata_i[CB_IRQEN];
            ctrl_o.rst_en <= pwdata_i[CB_RSTEN];
         end
         if (wr_pscl) pscl_o <= pwdata_i[PRE_W-1:0];
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NMATCH; gi++) begin : g_mreg
         localparam reg_idx_e MY_IDX = (gi == 0) ? IDX_MAT0 : IDX_MAT1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      mval_o[gi] <= '0;
            else if (wr && (idx == MY_IDX))  mval_o[gi] <= pwdata_i[CNT_W-1:0];
         end
      end
   endgenerate

   // Early-warning flag: set has priority over a write-1-to-clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              m0_flag_o <= 1'b0;
      else if (hit_i[0])                       m0_flag_o <= 1'b1;
      else if (wr_stat && pwdata_i[SB_M0])     m0_flag_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req_o <= 1'b0;
      else        rst_req_o <= fire_rst;
   end

   // Cause flag lives in the power-on domain only.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                              cause_o <= 1'b0;
      else if (fire_rst && rst_n)              cause_o <= 1'b1;
      else if (wr_stat && pwdata_i[SB_CAUSE])  cause_o <= 1'b0;
   end

   always_comb begin
      prdata_o = '0;
      if (psel_i && in_win) begin
         unique case (idx)
            IDX_CTRL: begin
               prdata_o[CB_RUN]   = ctrl_o.run;
               prdata_o[CB_IRQEN] = ctrl_o.irq_en;
               prdata_o[CB_RSTEN] = ctrl_o.rst_en;
            end
            IDX_TCNT: prdata_o = DATA_W'(tcnt_i);
            IDX_PSCL: prdata_o = DATA_W'(pscl_o);
            IDX_PCNT: prdata_o = DATA_W'(pcnt_i);
            IDX_MAT0: prdata_o = DATA_W'(mval_o[0]);
            IDX_MAT1: prdata_o = DATA_W'(mval_o[1]);
            IDX_STAT: begin
               prdata_o[SB_M0]    = m0_flag_o;
               prdata_o[SB_CAUSE] = cause_o;
            end
            IDX_FEED: prdata_o = '0;
            default:  prdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/escal_watchdog.sv
`timescale 1ns/1ps
module escal_watchdog
   import ewd_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 32
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              irq_o,
   output logic              rst_req_o
);

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 1..DATA_W");
   end
   if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre
      $error("PRE_W must lie in 1..DATA_W");
   end
   if (ADDR_W < WIN_BITS) begin : g_bad_addr
      $error("ADDR_W too small for the register window");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("DATA_W too small for the control bits");
   end

   logic                         sys_rst_n;
   ctrl_t                        ctrl;
   logic                         clr;
   logic [PRE_W-1:0]             pscl;
   logic [PRE_W-1:0]             pcnt;
   logic [CNT_W-1:0]             tcnt;
   logic [CNT_W-1:0]             tnext;
   logic                         step;
   logic [NMATCH-1:0][CNT_W-1:0] mval;
   logic [NMATCH-1:0]            hit;
   logic                         m0_flag;
   logic                         cause_flag;

   assign sys_rst_n = rst_n & por_n;

   ewd_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .PRE_W  (PRE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (sys_rst_n),
      .por_n     (por_n),
      .psel_i    (psel),
      .penable_i (penable),
      .pwrite_i  (pwrite),
      .paddr_i   (paddr),
      .pwdata_i  (pwdata),
      .prdata_o  (prdata),
      .tcnt_i    (tcnt),
      .pcnt_i    (pcnt),
      .hit_i     (hit),
      .ctrl_o    (ctrl),
      .clr_o     (clr),
      .pscl_o    (pscl),
      .mval_o    (mval),
      .m0_flag_o (m0_flag),
      .cause_o   (cause_flag),
      .rst_req_o (rst_req_o)
   );

   ewd_counters #(
      .CNT_W (CNT_W),
      .PRE_W (PRE_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (sys_rst_n),
      .run_i   (ctrl.run),
      .clr_i   (clr),
      .pscl_i  (pscl),
      .pcnt_o  (pcnt),
      .tcnt_o  (tcnt),
      .step_o  (step),
      .tnext_o (tnext)
   );

   genvar gm;
   generate
      for (gm = 0; gm < NMATCH; gm++) begin : g_cmp
         ewd_match #(.CNT_W(CNT_W)) u_match (
            .step_i  (step),
            .tnext_i (tnext),
            .mval_i  (mval[gm]),
            .hit_o   (hit[gm])
         );
      end
   endgenerate

   assign irq_o = m0_flag & ctrl.irq_en;

endmodule

// File: rtl/ewd_checker.sv
`timescale 1ns/1ps
module ewd_checker #(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 32
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic              irq_o,
   input logic              rst_req_o,
   input logic              run,
   input logic [CNT_W-1:0]  tcnt,
   input logic [PRE_W-1:0]  pcnt,
   input logic [PRE_W-1:0]  pscl,
   input logic              cause_flag
);

   logic wr_acc;
   assign wr_acc = psel && penable && pwrite;

   p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      rst_req_o |=> !rst_req_o);

   p_cause_set_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      rst_req_o |-> cause_flag);

   p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (irq_o && !wr_acc) |=> irq_o);

   p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (!run && !wr_acc) |=> ($stable(tcnt) && $stable(pcnt)));

   p_no_evt_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !run |=> !rst_req_o);

   p_feed_clears_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (wr_acc && paddr == ADDR_W'(ewd_pkg::OFS_FEED)) |=> (tcnt == '0 && pcnt == '0));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (run && !wr_acc && pcnt == pscl) |=> (pcnt == '0 && tcnt == CNT_W'($past(tcnt) + 1'b1)));

endmodule

bind escal_watchdog ewd_checker #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .PRE_W  (PRE_W)
) u_ewd_chk (
   .clk        (clk),
   .por_n      (por_n),
   .rst_n      (rst_n),
   .psel       (psel),
   .penable    (penable),
   .pwrite     (pwrite),
   .paddr      (paddr),
   .irq_o      (irq_o),
   .rst_req_o  (rst_req_o),
   .run        (ctrl.run),
   .tcnt       (tcnt),
   .pcnt       (pcnt),
   .pscl       (pscl),
   .cause_flag (cause_flag)
);

// File: tb/escal_watchdog_bench.sv
`timescale 1ns/1ps
module escal_watchdog_bench;
   import ewd_pkg::*;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 8;
   localparam int PRE_W  = 4;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              rst_n = 1'b0;
   logic              psel = 1'b0;
   logic              penable = 1'b0;
   logic              pwrite = 1'b0;
   logic [ADDR_W-1:0] paddr = '0;
   logic [DATA_W-1:0] pwdata = '0;
   logic [DATA_W-1:0] prdata;
   logic              irq_o;
   logic              rst_req_o;

   int checks = 0;
   int failures = 0;
   int pulses = 0;
   bit done = 0;

   always #4 clk = ~clk;

   escal_watchdog #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .PRE_W  (PRE_W)
   ) u_escal_watchdog (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .psel      (psel),
      .penable   (penable),
      .pwrite    (pwrite),
      .paddr     (paddr),
      .pwdata    (pwdata),
      .prdata    (prdata),
      .irq_o     (irq_o),
      .rst_req_o (rst_req_o)
   );

   always @(negedge clk) if (rst_req_o) pulses++;

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic bus_wr(input int a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      psel = 1; pwrite = 1; penable = 0; paddr = ADDR_W'(a); pwdata = d;
      @(negedge clk);
      penable = 1;
      @(posedge clk);
      #1;
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic bus_rd(input int a, output logic [DATA_W-1:0] d);
      @(negedge clk);
      psel = 1; pwrite = 0; penable = 0; paddr = ADDR_W'(a);
      @(negedge clk);
      penable = 1;
      #1;
      d = prdata;
      @(posedge clk);
      #1;
      psel = 0; penable = 0;
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!irq_o && n < 4000) begin
         @(posedge clk); #1; n++;
      end
   endtask

   task automatic wait_rst(output int n, output int ni);
      n = 0; ni = -1;
      while (!rst_req_o && n < 4000) begin
         @(posedge clk); #1; n++;
         if (irq_o && ni < 0) ni = n;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [DATA_W-1:0] rd;
      int n, ni;
      int mv[3] = '{1, 2, 5};

      repeat (3) @(negedge clk);
      por_n = 1; rst_n = 1;
      @(negedge clk);

      // R1 reset state
      bus_rd(OFS_CTRL, rd); chk("R1 ctrl", rd, 0);
      bus_rd(OFS_TCNT, rd); chk("R1 tcnt", rd, 0);
      bus_rd(OFS_PSCL, rd); chk("R1 pscl", rd, 0);
      bus_rd(OFS_MAT1, rd); chk("R1 mat1", rd, 0);
      bus_rd(OFS_STAT, rd); chk("R1 stat", rd, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 rst_req", rst_req_o, 0);

      // R10 map and R9 unassigned
      bus_wr(OFS_PSCL, 5);
      bus_wr(OFS_MAT0, 'h3C);
      bus_wr(OFS_MAT1, 'hA5);
      bus_wr(OFS_CTRL, 'hE);
      bus_rd(OFS_CTRL, rd); chk("R10 ctrl bits, clear reads 0", rd, 'hC);
      bus_wr(OFS_CTRL, 0);
      bus_rd(OFS_MAT0, rd); chk("R10 mat0", rd, 'h3C);
      bus_rd(OFS_MAT1, rd); chk("R10 mat1", rd, 'hA5);
      bus_wr('h24, 'hFFFF);
      bus_wr('h09, 'h3);
      bus_wr('h48, 'h7);
      bus_rd('h24, rd); chk("R9 unassigned read", rd, 0);
      bus_rd('h09, rd); chk("R9 unaligned read", rd, 0);
      bus_rd(OFS_PSCL, rd); chk("R9 pscl untouched", rd, 5);
      bus_rd(OFS_FEED, rd); chk("R10 feed reads 0", rd, 0);

      // R2 and R3 sweep over prescale and compare values
      for (int pr = 0; pr < 4; pr++) begin
         for (int k = 0; k < 3; k++) begin
            bus_wr(OFS_CTRL, 0);
            bus_wr(OFS_FEED, 0);
            bus_wr(OFS_PSCL, pr);
            bus_wr(OFS_MAT0, mv[k]);
            bus_wr(OFS_STAT, 3);
            bus_wr(OFS_CTRL, 'h5);
            wait_irq(n);
            chk($sformatf("R2 R3 clocks to irq pr=%0d k=%0d", pr, mv[k]), n, mv[k] * (pr + 1));
         end
      end

      // R3 hold and write-1-to-clear; R8 no re-trigger while parked on the value
      bus_wr(OFS_CTRL, 0);
      bus_wr(OFS_FEED, 0);
      bus_wr(OFS_PSCL, 15);
      bus_wr(OFS_MAT0, 1);
      bus_wr(OFS_STAT, 3);
      bus_wr(OFS_CTRL, 'h5);
      wait_irq(n);
      chk("R2 slow prescale irq time", n, 16);
      repeat (10) @(posedge clk);
      #1; chk("R3 irq held", irq_o, 1);
      bus_wr(OFS_STAT, 1);
      @(posedge clk); #1;
      chk("R3 irq cleared by W1C", irq_o, 0);
      bus_rd(OFS_TCNT, rd); chk("R8 still parked on value", rd, 1);
      bus_rd(OFS_STAT, rd); chk("R8 no re-trigger", rd, 0);

      // R3 interrupt enable gating
      bus_wr(OFS_CTRL, 0);
      bus_wr(OFS_FEED, 0);
      bus_wr(OFS_PSCL, 0);
      bus_wr(OFS_MAT0, 2);
      bus_wr(OFS_STAT, 3);
      bus_wr(OFS_CTRL, 'h1);
      repeat (10) @(posedge clk);
      #1; chk("R3 irq masked", irq_o, 0);
      bus_rd(OFS_STAT, rd); chk("R3 flag set while masked", rd, 1);
      bus_wr(OFS_CTRL, 'h5);
      chk("R3 irq on unmask", irq_o, 1);

      // R8 wrap from all ones to zero
      bus_wr(OFS_CTRL, 0);
      bus_wr(OFS_FEED, 0);
      bus_wr(OFS_MAT0, 0);
      bus_wr(OFS_STAT, 3);
      bus_wr(OFS_CTRL, 'h5);
      wait_irq(n);
      chk("R8 wrap match of zero", n, 256);

      // R7 stopped counters hold, no events
      bus_wr(OFS_CTRL, 0);
      bus_wr(OFS_MAT0, 1);
      bus_wr(OFS_FEED, 0);
      bus_wr(OFS_STAT, 3);
      repeat (20) @(posedge clk);
      #1;
      bus_rd(OFS_STAT, rd); chk("R7 no event when stopped", rd, 0);
      bus_rd(OFS_TCNT, rd); chk("R7 tcnt held", rd, 0);
      bus_rd(OFS_PCNT, rd); chk("R7 pcnt held", rd, 0);

      // R6 reload and control clear
      bus_wr(OFS_PSCL, 15);
      bus_wr(OFS_CTRL, 1);
      repeat (40) @(posedge clk);
      bus_wr(OFS_FEED, 'hDEAD);
      bus_wr(OFS_CTRL, 0);
      bus_rd(OFS_TCNT, rd); chk("R6 feed clears tcnt", rd, 0);
      bus_rd(OFS_PCNT, rd); chk("R6 pcnt counts after feed", rd, 2);
      bus_wr(OFS_CTRL, 1);
      repeat (40) @(posedge clk);
      bus_wr(OFS_CTRL, 'h2);
      bus_rd(OFS_TCNT, rd); chk("R6 ctrl clear tcnt", rd, 0);
      bus_rd(OFS_PCNT, rd); chk("R6 ctrl clear pcnt", rd, 0);
      repeat (5) @(posedge clk);
      bus_rd(OFS_PCNT, rd); chk("R7 held after clear", rd, 0);

      // R11 reset arm clear: no request
      bus_wr(OFS_PSCL, 1);
      bus_wr(OFS_MAT1, 3);
      bus_wr(OFS_STAT, 3);
      pulses = 0;
      bus_wr(OFS_CTRL, 'h1);
      repeat (20) @(posedge clk);
      #1; chk("R11 no reset request", pulses, 0);
      bus_rd(OFS_STAT, rd); chk("R11 cause stays clear", rd & 2, 0);

      // R4 escalation order and pulse width
      bus_wr(OFS_CTRL, 0);
      bus_wr(OFS_FEED, 0);
      bus_wr(OFS_MAT0, 1);
      bus_wr(OFS_STAT, 3);
      bus_wr(OFS_CTRL, 'hD);
      wait_rst(n, ni);
      chk("R4 clocks to reset request", n, 6);
      chk("R3 irq before reset", ni, 2);
      @(posedge clk); #1;
      chk("R4 one-cycle pulse", rst_req_o, 0);
      bus_wr(OFS_CTRL, 0);
      bus_rd(OFS_STAT, rd); chk("R5 cause set", rd, 3);

      // R5 survives system reset
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk); rst_n = 1;
      bus_rd(OFS_STAT, rd); chk("R5 cause survives rst_n", rd, 2);
      bus_rd(OFS_CTRL, rd); chk("R1 ctrl after rst_n", rd, 0);
      bus_wr(OFS_STAT, 2);
      bus_rd(OFS_STAT, rd); chk("R5 cause W1C", rd, 0);

      // R5 cleared by power-on reset
      bus_wr(OFS_MAT1, 2);
      bus_wr(OFS_CTRL, 'h9);
      wait_rst(n, ni);
      chk("R4 prescale 0 request time", n, 2);
      bus_wr(OFS_CTRL, 0);
      bus_rd(OFS_STAT, rd); chk("R5 cause set again", rd, 2);
      @(negedge clk); por_n = 0;
      repeat (2) @(negedge clk); por_n = 1;
      bus_rd(OFS_STAT, rd); chk("R5 cleared by por_n", rd, 0);

      finish_run();
   end

endmodule